// File: doc/BRIEF.md
# Address-Keyed Retry Timer Table

This block keeps a small set of countdown timers, each tagged with a line address. A coherence controller arms a timer when an operation on a line has to wait. It uses a short retry delay when an escalated request cannot be sent yet, and a long delay as a stall timeout. When a timer runs out, the block shows that line address on a ready output until the controller acknowledges it. The acknowledge frees the slot.

The controller can also cancel a timer, ask whether a line has a timer armed, and re-arm an armed timer with the long delay. Re-arming is conditional: when the line has no timer, the request does nothing. A set to a line that already has a timer restarts that timer rather than taking a second slot. A set that finds every slot in use by other lines is dropped and flagged.

Top module: `reissue_timer_table`

## Requirements
- R1: After a synchronous reset, no timer is armed, `rdy_valid` is 0, `overflow` is 0 and `query_hit` is 0.
- R2: Command code 0 (short set) applied at a clock edge arms a timer for `cmd_addr`. `rdy_valid` rises exactly SHORT_LAT edges later (default 10), with `rdy_addr` equal to that address.
- R3: Command code 1 (long set) behaves as R2, but the delay is LONG_LAT edges (default 100).
- R4: A set to an address that already has a timer restarts its count from the new delay without taking another slot. Such a set does not raise `overflow`, even when every slot is in use.
- R5: Command code 2 (cancel) removes the timer of `cmd_addr`, so the timer never reaches the ready output. A cancel for an address with no timer changes nothing.
- R6: `query_hit` is registered. One edge after `query_addr` is sampled, it shows whether that address had a timer armed before that edge. A timer that has expired but is not yet acknowledged counts as armed.
- R7: Command code 3 (re-arm) restarts an armed timer with LONG_LAT. For an address with no timer it allocates nothing and raises no `overflow`.
- R8: Once an address is on the ready output, `rdy_valid` and `rdy_addr` stay unchanged until `rdy_ack`, unless a command targets that address. Even a lower-slot timer that expires meanwhile does not displace it. Other timers keep counting in the meantime.
- R9: A new timer goes into the lowest free slot. When several timers are waiting, the one in the lowest slot is shown first. The next waiting one is shown on the edge that takes the acknowledge.
- R10: A set for a new address while all DEPTH slots are occupied is dropped. `overflow` is then 1 for exactly one cycle.
- R11: `rdy_ack` while `rdy_valid` is 0 has no effect.
- R12: An acknowledge and a command can take effect on the same edge. A set to the address being acknowledged wins: the timer is re-armed and `rdy_valid` drops. A slot freed by that acknowledge cannot be used by a set on the same edge, so a set for a new address into a full table overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 short set, 1 long set, 2 cancel, 3 re-arm |
| cmd_addr | input | ADDR_W | Line address of the command |
| query_addr | input | ADDR_W | Address tested for an armed timer |
| query_hit | output | 1 | Registered result of the test |
| rdy_ack | input | 1 | Consumer acknowledge of the shown address |
| rdy_valid | output | 1 | An expired timer is being shown |
| rdy_addr | output | ADDR_W | Address of the expired timer |
| overflow | output | 1 | One-cycle pulse: a set was dropped |

## Verification
The acknowledge of an expired timer and a new command can land on the same clock edge, and the bench forces that collision in two ways. In the first case, it acknowledges a shown address while setting that same address again. It then expects the ready output to drop, the query to report the line armed, and a fresh expiry exactly one short delay later. In the second case, the table is full and the acknowledge arrives on the edge that brings a set for an unseen address. The bench expects the overflow pulse and a negative query for the dropped address.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [1:0] {
    OP_SET_SHORT = 2'd0,
    OP_SET_LONG  = 2'd1,
    OP_CANCEL    = 2'd2,
    OP_REARM     = 2'd3
  } rtt_op_e;
endpackage

// File: rtl/rtt_pick.sv
// Lowest-set-bit isolation: grant is one-hot (or zero) on the lowest request.
module rtt_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  assign gnt = req & (~req + N'(1));
endmodule

// File: rtl/rtt_match.sv
// Parallel address compare across all slots.
module rtt_match #(
  parameter int N      = 4,
  parameter int ADDR_W = 16
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][ADDR_W-1:0] addrs,
  input  logic [ADDR_W-1:0]        key,
  output logic [N-1:0]             hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = valid[i] && (addrs[i] == key);
  end
endmodule

// File: rtl/rtt_entry.sv
// One timer slot: tag, down-counter and expired flag.
module rtt_entry #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clear,
  input  logic [CNT_W-1:0]  lat,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              valid_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              exp_d
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              valid_d, expired_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    exp_d   = expired_q;
    if (load) begin
      valid_d = 1'b1;
      addr_d  = addr_in;
      cnt_d   = lat;
      exp_d   = 1'b0;
    end else if (clear) begin
      valid_d = 1'b0;
      cnt_d   = '0;
      exp_d   = 1'b0;
    end else if (valid_q && !expired_q) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d = '0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      addr_q    <= '0;
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      addr_q    <= addr_d;
      cnt_q     <= cnt_d;
      expired_q <= exp_d;
    end
  end
endmodule

// File: rtl/reissue_timer_table.sv
module reissue_timer_table
  import rtt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DEPTH     = 4,
  parameter int SHORT_LAT = 10,
  parameter int LONG_LAT  = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] query_addr,
  output logic              query_hit,
  input  logic              rdy_ack,
  output logic              rdy_valid,
  output logic [ADDR_W-1:0] rdy_addr,
  output logic              overflow
);
  localparam int MAX_LAT = (LONG_LAT > SHORT_LAT) ? LONG_LAT : SHORT_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_LAT);
  localparam logic [CNT_W-1:0] LONG_CNT  = CNT_W'(LONG_LAT);

  function automatic logic [IDX_W-1:0] onehot_to_idx(input logic [DEPTH-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (oh[k]) r = r | IDX_W'(k);
    end
    return r;
  endfunction

  rtt_op_e op;
  assign op = rtt_op_e'(cmd_op);

  logic [DEPTH-1:0]             ent_valid, ent_exp_d, cmd_hit, qry_hit;
  logic [DEPTH-1:0]             free_gnt, exp_gnt, ld_vec, clr_vec;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic                         do_set, do_cancel, do_rearm, hit_any, free_any;
  logic                         acked, keep_cur, exp_any;
  logic [CNT_W-1:0]             ld_lat;
  logic [IDX_W-1:0]             rdy_idx_q, exp_idx;
  logic                         rdy_valid_q, query_hit_q, overflow_q;
  logic [ADDR_W-1:0]            rdy_addr_q;

  rtt_match #(.N(DEPTH), .ADDR_W(ADDR_W)) u_cmd_match (
    .valid(ent_valid), .addrs(ent_addr), .key(cmd_addr), .hit(cmd_hit)
  );
  rtt_match #(.N(DEPTH), .ADDR_W(ADDR_W)) u_qry_match (
    .valid(ent_valid), .addrs(ent_addr), .key(query_addr), .hit(qry_hit)
  );
  rtt_pick #(.N(DEPTH)) u_free_pick (.req(~ent_valid), .gnt(free_gnt));
  rtt_pick #(.N(DEPTH)) u_exp_pick  (.req(ent_exp_d),  .gnt(exp_gnt));

  assign do_set    = cmd_valid && (op == OP_SET_SHORT || op == OP_SET_LONG);
  assign do_cancel = cmd_valid && (op == OP_CANCEL);
  assign do_rearm  = cmd_valid && (op == OP_REARM);
  assign hit_any   = |cmd_hit;
  assign free_any  = |free_gnt;
  assign ld_lat    = (op == OP_SET_SHORT) ? SHORT_CNT : LONG_CNT;
  assign acked     = rdy_ack && rdy_valid_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign ld_vec[i]  = (do_set && (cmd_hit[i] || (!hit_any && free_gnt[i])))
                      || (do_rearm && cmd_hit[i]);
    assign clr_vec[i] = (do_cancel && cmd_hit[i])
                      || (acked && (rdy_idx_q == IDX_W'(i)));
    rtt_entry #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_entry (
      .clk(clk), .rst(rst), .load(ld_vec[i]), .clear(clr_vec[i]),
      .lat(ld_lat), .addr_in(cmd_addr),
      .valid_q(ent_valid[i]), .addr_q(ent_addr[i]), .exp_d(ent_exp_d[i])
    );
  end

  // The shown entry stays shown while it is still expired after this edge.
  assign keep_cur = rdy_valid_q && ent_exp_d[rdy_idx_q];
  assign exp_any  = |exp_gnt;
  assign exp_idx  = onehot_to_idx(exp_gnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_valid_q <= 1'b0;
      rdy_idx_q   <= '0;
      rdy_addr_q  <= '0;
      query_hit_q <= 1'b0;
      overflow_q  <= 1'b0;
    end else begin
      if (keep_cur) begin
        rdy_valid_q <= 1'b1;
      end else if (exp_any) begin
        rdy_valid_q <= 1'b1;
        rdy_idx_q   <= exp_idx;
        rdy_addr_q  <= ent_addr[exp_idx];
      end else begin
        rdy_valid_q <= 1'b0;
        rdy_addr_q  <= '0;
      end
      query_hit_q <= |qry_hit;
      overflow_q  <= do_set && !hit_any && !free_any;
    end
  end

  assign rdy_valid = rdy_valid_q;
  assign rdy_addr  = rdy_addr_q;
  assign query_hit = query_hit_q;
  assign overflow  = overflow_q;
endmodule

// File: rtl/rtt_chk.sv
module rtt_chk #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              rdy_ack,
  input logic              rdy_valid,
  input logic [ADDR_W-1:0] rdy_addr,
  input logic              overflow,
  input logic [DEPTH-1:0]  ent_valid,
  input logic [DEPTH-1:0]  cmd_hit
);
  logic set_full_miss;
  assign set_full_miss = cmd_valid && !cmd_op[1] && (cmd_hit == '0) && (&ent_valid);

  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!rdy_valid && !overflow));

  // R8
  rdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_valid && !rdy_ack && !(cmd_valid && cmd_addr == rdy_addr))
      |=> (rdy_valid && rdy_addr == $past(rdy_addr)));

  // R10
  overflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
    set_full_miss |=> overflow);

  // R10
  no_spurious_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !set_full_miss |=> !overflow);

  // R4
  unique_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_hit));

  // R7
  rearm_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3 && cmd_hit == '0 && !rdy_ack) |=> $stable(ent_valid));

  // R5
  cancel_gone_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2) |=> !(rdy_valid && rdy_addr == $past(cmd_addr)));

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdy_valid && rdy_ack && !cmd_valid) |=> $stable(ent_valid));
endmodule

bind reissue_timer_table rtt_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
  .rdy_ack(rdy_ack), .rdy_valid(rdy_valid), .rdy_addr(rdy_addr), .overflow(overflow),
  .ent_valid(ent_valid), .cmd_hit(cmd_hit)
);

// File: tb/reissue_timer_table_tb.sv
module reissue_timer_table_tb_top;
  localparam logic [1:0] SET_S = 2'd0, SET_L = 2'd1, CANCEL = 2'd2, REARM = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_addr = '0;
  logic [15:0] query_addr = '0;
  logic        rdy_ack = 1'b0;
  logic        query_hit, rdy_valid, overflow;
  logic [15:0] rdy_addr;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  reissue_timer_table dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .query_addr(query_addr), .query_hit(query_hit), .rdy_ack(rdy_ack),
    .rdy_valid(rdy_valid), .rdy_addr(rdy_addr), .overflow(overflow)
  );

  // {cmd_valid, op, cmd_addr, query_addr, expected query_hit after the edge}
  localparam logic [35:0] VEC [0:10] = '{
    {1'b1, SET_S,  16'h0010, 16'h0010, 1'b0},
    {1'b0, SET_S,  16'h0000, 16'h0010, 1'b1},
    {1'b1, CANCEL, 16'h0020, 16'h0010, 1'b1},
    {1'b1, CANCEL, 16'h0010, 16'h0010, 1'b1},
    {1'b0, SET_S,  16'h0000, 16'h0010, 1'b0},
    {1'b1, REARM,  16'h0030, 16'h0030, 1'b0},
    {1'b0, SET_S,  16'h0000, 16'h0030, 1'b0},
    {1'b1, SET_L,  16'h0030, 16'h0030, 1'b0},
    {1'b1, REARM,  16'h0030, 16'h0030, 1'b1},
    {1'b1, CANCEL, 16'h0030, 16'h0030, 1'b1},
    {1'b0, SET_S,  16'h0000, 16'h0030, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] a);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic ack();
    rdy_ack = 1'b1;
    step();
    rdy_ack = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic query(input logic [15:0] a, input logic exp, input string tag);
    query_addr = a;
    step();
    check(tag, 32'(query_hit), 32'(exp));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    step();
    // R1 reset state
    check("R1 rdy_valid", 32'(rdy_valid), 0);
    check("R1 overflow", 32'(overflow), 0);
    query(16'h0010, 1'b0, "R1 query");

    // R5 R6 R7 vector walk
    for (int r = 0; r < 11; r++) begin
      cmd_valid  = VEC[r][35];
      cmd_op     = VEC[r][34:33];
      cmd_addr   = VEC[r][32:17];
      query_addr = VEC[r][16:1];
      step();
      check($sformatf("R6 (R5 R7) row %0d", r), 32'(query_hit), 32'(VEC[r][0]));
    end
    cmd_valid = 1'b0;

    // R2 short delay, R11 idle ack, R8 hold
    issue(SET_S, 16'h0055);
    idle(2);
    ack();
    idle(5);
    idle(1);
    check("R2 early", 32'(rdy_valid), 0);
    idle(1);
    check("R2 valid", 32'(rdy_valid), 1);
    check("R11 R2 addr", 32'(rdy_addr), 32'h55);
    idle(3);
    check("R8 hold valid", 32'(rdy_valid), 1);
    check("R8 hold addr", 32'(rdy_addr), 32'h55);
    ack();
    check("R8 ack drops", 32'(rdy_valid), 0);
    query(16'h0055, 1'b0, "R6 freed by ack");

    // R3 long delay
    issue(SET_L, 16'h0066);
    idle(99);
    check("R3 early", 32'(rdy_valid), 0);
    idle(1);
    check("R3 valid", 32'(rdy_valid), 1);
    check("R3 addr", 32'(rdy_addr), 32'h66);
    ack();

    // R4 reload of a present address
    issue(SET_S, 16'h0077);
    idle(4);
    issue(SET_S, 16'h0077);
    idle(9);
    check("R4 reloaded not yet", 32'(rdy_valid), 0);
    idle(1);
    check("R4 reloaded expiry", 32'(rdy_valid), 1);
    ack();

    // R7 re-arm of a present timer
    issue(SET_S, 16'h0088);
    idle(3);
    issue(REARM, 16'h0088);
    idle(99);
    check("R7 rearm early", 32'(rdy_valid), 0);
    idle(1);
    check("R7 rearm expiry", 32'(rdy_addr), 32'h88);
    ack();

    // R9 simultaneous expiry, lowest slot first
    issue(SET_L, 16'h00D0);
    idle(89);
    issue(SET_S, 16'h00D1);
    idle(9);
    check("R9 none yet", 32'(rdy_valid), 0);
    idle(1);
    check("R9 first", 32'(rdy_addr), 32'hD0);
    ack();
    check("R9 second valid", 32'(rdy_valid), 1);
    check("R9 second", 32'(rdy_addr), 32'hD1);
    ack();
    check("R9 drained", 32'(rdy_valid), 0);

    // R8 shown entry is not displaced by a lower slot
    issue(SET_L, 16'h00C0);
    issue(SET_S, 16'h00C1);
    idle(10);
    check("R8 shows slot1", 32'(rdy_addr), 32'hC1);
    idle(90);
    check("R8 still slot1", 32'(rdy_addr), 32'hC1);
    ack();
    check("R8 then slot0", 32'(rdy_addr), 32'hC0);
    ack();

    // R10 overflow
    issue(SET_L, 16'h00E0);
    issue(SET_L, 16'h00E1);
    issue(SET_L, 16'h00E2);
    issue(SET_L, 16'h00E3);
    issue(SET_S, 16'h00E4);
    check("R10 overflow pulse", 32'(overflow), 1);
    query(16'h00E4, 1'b0, "R10 dropped");
    check("R10 pulse ends", 32'(overflow), 0);
    issue(SET_S, 16'h00E1);
    check("R4 full reload no overflow", 32'(overflow), 0);
    issue(REARM, 16'h00E5);
    check("R7 rearm miss no overflow", 32'(overflow), 0);
    issue(CANCEL, 16'h00E0);
    issue(CANCEL, 16'h00E1);
    issue(CANCEL, 16'h00E2);
    issue(CANCEL, 16'h00E3);
    query(16'h00E2, 1'b0, "R5 cancelled");

    // R12 ack and set of the same address on one edge
    issue(SET_S, 16'h00F0);
    idle(10);
    check("R12 shown", 32'(rdy_addr), 32'hF0);
    rdy_ack = 1'b1;
    issue(SET_S, 16'h00F0);
    rdy_ack = 1'b0;
    check("R12 rearmed drops", 32'(rdy_valid), 0);
    query(16'h00F0, 1'b1, "R12 still armed");
    idle(8);
    check("R12 not yet", 32'(rdy_valid), 0);
    idle(1);
    check("R12 expires again", 32'(rdy_addr), 32'hF0);
    ack();

    // R12 ack frees a slot on the edge of a set into a full table
    issue(SET_S, 16'h00A0);
    issue(SET_L, 16'h00A1);
    issue(SET_L, 16'h00A2);
    issue(SET_L, 16'h00A3);
    idle(7);
    check("R12 full shown", 32'(rdy_addr), 32'hA0);
    rdy_ack = 1'b1;
    issue(SET_S, 16'h00A4);
    rdy_ack = 1'b0;
    check("R12 full overflow", 32'(overflow), 1);
    check("R12 full ack taken", 32'(rdy_valid), 0);
    query(16'h00A4, 1'b0, "R12 full dropped");
    issue(CANCEL, 16'h00A1);
    issue(CANCEL, 16'h00A2);
    issue(CANCEL, 16'h00A3);

    finish_run();
  end
endmodule